// File: doc/BRIEF.md
# External Event Timestamp Capture

This block records the moment a signal edge arrives on one of several asynchronous input pins. Each pin is brought into the clock domain through a two-stage synchronizer. A third registered copy of the synchronized level is used to detect edges. When a selected edge is found on an enabled channel, the block takes the time-of-day bus (seconds and nanoseconds) present on that clock edge. It subtracts a signed latency correction, with borrow or carry into the seconds field, and writes the result into a small first-in-first-out queue.

Software drains the queue through a valid/ready pair. Each entry carries the channel number together with the corrected seconds and nanoseconds. A pin change is stamped two clock cycles after the clock edge that first samples it, so the stamp has one clock period (8 ns) of resolution. An edge that lands near a sampling edge therefore resolves to one of two neighbouring stamps.

When the queue cannot take an event, the event is lost and a sticky flag records the loss. The time counter, pin routing and interrupt signalling sit outside this block.

Top module: `evt_stamp_capture`

## Requirements
- R1: After reset `evtValid` and `overflow` are both 0.
- R2: A pin level first sampled at clock edge k produces an entry whose stamp is the time bus value at edge k+2; `evtValid` is 0 after edges k and k+1 and is 1 after edge k+2.
- R3: Bit c of `riseEn` selects 0-to-1 transitions of channel c and bit c of `fallEn` selects 1-to-0 transitions; with both bits set, one high pulse yields two entries spaced by the pulse width, and an unselected transition adds no entry.
- R4: A channel whose `chEnable` bit is 0 adds no entry for any transition.
- R5: The stored nanoseconds equal the time bus nanoseconds minus the signed `corrNs` value; a result below 0 adds 1,000,000,000 and decrements seconds, and a result at or above 1,000,000,000 subtracts 1,000,000,000 and increments seconds.
- R6: Each entry reports the index of the channel that produced it on `evtChan`, with channel 0 = bit 0 of `evtPin`.
- R7: The queue holds up to DEPTH (8) entries and returns them oldest first. The head is removed on a clock edge where `evtValid` and `evtReady` are both 1, and the head is held unchanged while `evtReady` is 0.
- R8: An event that finds no free slot is dropped and sets `overflow`, which then stays 1 until reset; a slot freed by a removal on the same edge is available to a new event.
- R9: Events from several channels on the same clock edge are queued in ascending channel index order and carry identical stamps.
- R10: A pin change just before a sampling edge and one just after it receive stamps that differ by exactly one clock period (time at edge k+2 versus k+3).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Capture clock (8 ns period) |
| rstN | input | 1 | Asynchronous active-low reset |
| evtPin | input | NCH | Asynchronous event pins, one per channel |
| chEnable | input | NCH | Per-channel capture enable |
| riseEn | input | NCH | Per-channel rising-edge select |
| fallEn | input | NCH | Per-channel falling-edge select |
| timeSec | input | SEC_W | Current time, seconds |
| timeNs | input | NS_W | Current time, nanoseconds (below 1e9) |
| corrNs | input | CORR_W | Signed latency correction subtracted from the stamp |
| evtValid | output | 1 | Queue head holds an entry |
| evtReady | input | 1 | Consumer accepts the head entry |
| evtChan | output | CHW | Channel index of the head entry |
| evtSec | output | SEC_W | Corrected seconds of the head entry |
| evtNs | output | NS_W | Corrected nanoseconds of the head entry |
| overflow | output | 1 | Sticky flag: an event was dropped |

## Verification
The bound checker watches, on every cycle, that the loss flag never clears once set, that a waiting head entry stays frozen while the consumer stalls, that the occupancy never exceeds the depth, and that any presented nanoseconds field and channel number lie in range. The two-cycle synchronizer latency, the edge selection and enable gating, the borrow and carry of the correction, and the ordering of same-edge events across channels can only be shown by the bench's scenarios. Its behavioural model predicts the queue contents on every clock. The one-period split between a change just before and just after a sampling edge is likewise shown only by a directed scenario.

// File: rtl/evt_stamp_pkg.sv
package evt_stamp_pkg;

  // One second expressed in the nanoseconds field.
  localparam int unsigned NS_PER_SEC = 1_000_000_000;

  // Per-cycle strobes from control to datapath.
  typedef struct packed {
    logic pop;   // head entry leaves the queue this edge
    logic push;  // at least one event is written this edge
  } evt_strobe_t;

endpackage

// File: rtl/evt_stamp_sync.sv
// Two-stage synchronizer plus one history stage for edge detection.
module evt_stamp_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] asyncIn,
  output logic [W-1:0] lvlNow,
  output logic [W-1:0] lvlPrev
);

  logic [W-1:0] stg1, stg2, stg3;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stg1 <= '0;
      stg2 <= '0;
      stg3 <= '0;
    end else begin
      stg1 <= asyncIn;
      stg2 <= stg1;
      stg3 <= stg2;
    end
  end

  assign lvlNow  = stg2;
  assign lvlPrev = stg3;

endmodule

// File: rtl/evt_stamp_ctrl.sv
// Control: synchronizer, edge selection, slot admission, occupancy, loss flag.
module evt_stamp_ctrl
  import evt_stamp_pkg::*;
#(
  parameter int NCH   = 2,
  parameter int DEPTH = 8,
  parameter int CW    = $clog2(DEPTH) + 1
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [NCH-1:0] evtPin,
  input  logic [NCH-1:0] chEnable,
  input  logic [NCH-1:0] riseEn,
  input  logic [NCH-1:0] fallEn,
  input  logic           evtReady,
  output logic           evtValid,
  output logic           overflow,
  output logic [NCH-1:0] acceptVec,
  output evt_strobe_t    strb,
  output logic [CW-1:0]  fillCount
);

  logic [NCH-1:0] lvlNow, lvlPrev, hitVec;
  logic [CW-1:0]  nAccept;
  logic           dropAny;
  int             freeSlots, accCnt, hitCnt;

  evt_stamp_sync #(.W(NCH)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (evtPin),
    .lvlNow  (lvlNow),
    .lvlPrev (lvlPrev)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_hit
    assign hitVec[c] = chEnable[c] &
                       ((riseEn[c] &  lvlNow[c] & ~lvlPrev[c]) |
                        (fallEn[c] & ~lvlNow[c] &  lvlPrev[c]));
  end

  assign evtValid  = (fillCount != '0);
  assign strb.pop  = evtValid & evtReady;
  assign strb.push = |acceptVec;

  // Admit hits in ascending channel order while slots remain; a slot
  // vacated by this edge's removal counts as free.
  always_comb begin
    freeSlots = DEPTH - int'(fillCount) + int'(strb.pop);
    accCnt    = 0;
    hitCnt    = 0;
    acceptVec = '0;
    for (int c = 0; c < NCH; c++) begin
      if (hitVec[c]) begin
        if (hitCnt < freeSlots) begin
          acceptVec[c] = 1'b1;
          accCnt       = accCnt + 1;
        end
        hitCnt = hitCnt + 1;
      end
    end
    nAccept = CW'(accCnt);
    dropAny = (hitCnt != accCnt);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fillCount <= '0;
      overflow  <= 1'b0;
    end else begin
      fillCount <= fillCount - CW'(strb.pop) + nAccept;
      overflow  <= overflow | dropAny;
    end
  end

endmodule

// File: rtl/evt_stamp_dp.sv
// Datapath: latency correction, slot addressing, entry storage, head read.
module evt_stamp_dp
  import evt_stamp_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int DEPTH  = 8,
  parameter int SEC_W  = 32,
  parameter int NS_W   = 30,
  parameter int CORR_W = 20,
  parameter int CHW    = 1,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  evt_strobe_t       strb,
  input  logic [NCH-1:0]    acceptVec,
  input  logic [SEC_W-1:0]  timeSec,
  input  logic [NS_W-1:0]   timeNs,
  input  logic [CORR_W-1:0] corrNs,
  output logic [CHW-1:0]    evtChan,
  output logic [SEC_W-1:0]  evtSec,
  output logic [NS_W-1:0]   evtNs
);

  localparam int DW = ((NS_W > CORR_W) ? NS_W : CORR_W) + 2;
  localparam logic signed [DW-1:0] NSPS = DW'(NS_PER_SEC);

  logic signed [DW-1:0] rawNs;
  logic [SEC_W-1:0]     adjSec;
  logic [NS_W-1:0]      adjNs;

  // Corrected stamp, shared by every channel firing on this edge.
  always_comb begin
    rawNs  = $signed({{(DW-NS_W){1'b0}}, timeNs}) -
             $signed({{(DW-CORR_W){corrNs[CORR_W-1]}}, corrNs});
    adjSec = timeSec;
    adjNs  = NS_W'(rawNs);
    if (rawNs < 0) begin
      adjNs  = NS_W'(rawNs + NSPS);
      adjSec = timeSec - SEC_W'(1);
    end else if (rawNs >= NSPS) begin
      adjNs  = NS_W'(rawNs - NSPS);
      adjSec = timeSec + SEC_W'(1);
    end
  end

  logic [AW-1:0] wrPtr, rdPtr, wrStep;
  logic [AW-1:0] slot [NCH];

  // Accepted channels take consecutive slots, lowest index first.
  always_comb begin
    wrStep = '0;
    for (int c = 0; c < NCH; c++) begin
      slot[c] = wrPtr + wrStep;
      if (acceptVec[c]) wrStep = wrStep + AW'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      wrPtr <= wrPtr + wrStep;
      rdPtr <= rdPtr + AW'(strb.pop);
    end
  end

  logic [CHW-1:0]   memChan [DEPTH];
  logic [SEC_W-1:0] memSec  [DEPTH];
  logic [NS_W-1:0]  memNs   [DEPTH];

  always_ff @(posedge clk) begin
    if (strb.push) begin
      for (int c = 0; c < NCH; c++) begin
        if (acceptVec[c]) begin
          memChan[slot[c]] <= CHW'(c);
          memSec[slot[c]]  <= adjSec;
          memNs[slot[c]]   <= adjNs;
        end
      end
    end
  end

  assign evtChan = memChan[rdPtr];
  assign evtSec  = memSec[rdPtr];
  assign evtNs   = memNs[rdPtr];

endmodule

// File: rtl/evt_stamp_capture.sv
// Top: external event timestamp capture.
module evt_stamp_capture
  import evt_stamp_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int DEPTH  = 8,
  parameter int SEC_W  = 32,
  parameter int NS_W   = 30,
  parameter int CORR_W = 20,
  localparam int CHW   = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = AW + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NCH-1:0]    evtPin,
  input  logic [NCH-1:0]    chEnable,
  input  logic [NCH-1:0]    riseEn,
  input  logic [NCH-1:0]    fallEn,
  input  logic [SEC_W-1:0]  timeSec,
  input  logic [NS_W-1:0]   timeNs,
  input  logic [CORR_W-1:0] corrNs,
  output logic              evtValid,
  input  logic              evtReady,
  output logic [CHW-1:0]    evtChan,
  output logic [SEC_W-1:0]  evtSec,
  output logic [NS_W-1:0]   evtNs,
  output logic              overflow
);

  evt_strobe_t    strb;
  logic [NCH-1:0] acceptVec;
  logic [CW-1:0]  fillCount;

  evt_stamp_ctrl #(.NCH(NCH), .DEPTH(DEPTH), .CW(CW)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .evtPin    (evtPin),
    .chEnable  (chEnable),
    .riseEn    (riseEn),
    .fallEn    (fallEn),
    .evtReady  (evtReady),
    .evtValid  (evtValid),
    .overflow  (overflow),
    .acceptVec (acceptVec),
    .strb      (strb),
    .fillCount (fillCount)
  );

  evt_stamp_dp #(
    .NCH(NCH), .DEPTH(DEPTH), .SEC_W(SEC_W), .NS_W(NS_W),
    .CORR_W(CORR_W), .CHW(CHW), .AW(AW)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .acceptVec (acceptVec),
    .timeSec   (timeSec),
    .timeNs    (timeNs),
    .corrNs    (corrNs),
    .evtChan   (evtChan),
    .evtSec    (evtSec),
    .evtNs     (evtNs)
  );

endmodule

// File: rtl/evt_stamp_chk.sv
// Property checker, bound onto the capture top.
module evt_stamp_chk
  import evt_stamp_pkg::*;
#(
  parameter int NCH   = 2,
  parameter int DEPTH = 8,
  parameter int SEC_W = 32,
  parameter int NS_W  = 30,
  parameter int CHW   = 1,
  parameter int CW    = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             evtValid,
  input logic             evtReady,
  input logic [CHW-1:0]   evtChan,
  input logic [SEC_W-1:0] evtSec,
  input logic [NS_W-1:0]  evtNs,
  input logic             overflow,
  input logic [CW-1:0]    fillCount
);

  // R8
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);

  // R7
  head_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && !evtReady) |=> (evtValid && $stable(evtChan) &&
                                 $stable(evtSec) && $stable(evtNs)));

  // R7
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    int'(fillCount) <= DEPTH);

  // R5
  ns_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    evtValid |-> (int'(evtNs) < int'(NS_PER_SEC)));

  // R6
  chan_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    evtValid |-> (int'(evtChan) < NCH));

endmodule

bind evt_stamp_capture evt_stamp_chk #(
  .NCH(NCH), .DEPTH(DEPTH), .SEC_W(SEC_W), .NS_W(NS_W), .CHW(CHW), .CW(CW)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .evtValid  (evtValid),
  .evtReady  (evtReady),
  .evtChan   (evtChan),
  .evtSec    (evtSec),
  .evtNs     (evtNs),
  .overflow  (overflow),
  .fillCount (fillCount)
);

// File: tb/sim_evt_stamp_capture.sv
`timescale 1ns/1ps
module sim_evt_stamp_capture;

  localparam int NCH   = 2;
  localparam int DEPTH = 8;
  localparam longint NSPS = 1000000000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  evtPin = '0, chEnable = '0, riseEn = '0, fallEn = '0;
  logic [31:0] tSec = 32'd100;
  logic [29:0] tNs = '0;
  int          corrVal = 0;
  logic [19:0] corrNs;
  logic        evtReady = 1'b0;
  logic        evtValid, overflow;
  logic [0:0]  evtChan;
  logic [31:0] evtSec;
  logic [29:0] evtNs;

  assign corrNs = 20'(corrVal);

  int    checks = 0, fails = 0;
  string curReq = "R1";
  bit    done = 0;

  evt_stamp_capture u0 (
    .clk(clk), .rstN(rstN), .evtPin(evtPin), .chEnable(chEnable),
    .riseEn(riseEn), .fallEn(fallEn), .timeSec(tSec), .timeNs(tNs),
    .corrNs(corrNs), .evtValid(evtValid), .evtReady(evtReady),
    .evtChan(evtChan), .evtSec(evtSec), .evtNs(evtNs), .overflow(overflow)
  );

  always #4 clk = ~clk;

  // Time-of-day source: 8 ns per cycle, updated away from the active edge.
  always @(negedge clk) begin
    if (longint'(tNs) + 8 >= NSPS) begin
      tNs  = 30'(longint'(tNs) + 8 - NSPS);
      tSec = tSec + 1;
    end else begin
      tNs = tNs + 30'd8;
    end
  end

  // Behavioural reference model.
  typedef struct { int ch; longint sec; longint ns; } ent_t;
  ent_t     mq[$];
  bit       mOvf;
  bit [1:0] hA, hB, hC;

  function automatic ent_t stampOf(int c);
    ent_t e;
    longint n;
    n = longint'(tNs) - longint'(corrVal);
    e.ch  = c;
    e.sec = longint'(tSec);
    if (n < 0) begin n = n + NSPS; e.sec = e.sec - 1; end
    else if (n >= NSPS) begin n = n - NSPS; e.sec = e.sec + 1; end
    e.ns = n;
    return e;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mq.delete();
      mOvf = 0; hA = 0; hB = 0; hC = 0;
    end else begin
      if (mq.size() > 0 && evtReady) void'(mq.pop_front());
      for (int c = 0; c < NCH; c++) begin
        if (chEnable[c] && ((riseEn[c] && hB[c] && !hC[c]) ||
                            (fallEn[c] && !hB[c] && hC[c]))) begin
          if (mq.size() < DEPTH) mq.push_back(stampOf(c));
          else mOvf = 1;
        end
      end
      hC = hB; hB = hA; hA = evtPin;
    end
  end

  // Compare against the model on every clock.
  always @(negedge clk) begin
    if (rstN && !done) begin
      checks++;
      if (evtValid !== (mq.size() > 0) || overflow !== mOvf ||
          (mq.size() > 0 && (int'(evtChan) != mq[0].ch ||
                             longint'(evtSec) != mq[0].sec ||
                             longint'(evtNs) != mq[0].ns))) begin
        fails++;
        $display("FAIL %s model: actual v=%0b ch=%0d s=%0d ns=%0d ov=%0b expected v=%0b ch=%0d s=%0d ns=%0d ov=%0b",
                 curReq, evtValid, evtChan, evtSec, evtNs, overflow,
                 mq.size() > 0, (mq.size() > 0) ? mq[0].ch : 0,
                 (mq.size() > 0) ? mq[0].sec : 0,
                 (mq.size() > 0) ? mq[0].ns : 0, mOvf);
      end
    end
  end

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  int     drCh[16];
  longint drNs[16];
  longint drSec[16];

  task automatic drain(output int n);
    n = 0;
    @(negedge clk);
    evtReady = 1'b1;
    while (evtValid) begin
      if (n < 16) begin
        drCh[n] = int'(evtChan); drNs[n] = longint'(evtNs); drSec[n] = longint'(evtSec);
      end
      n++;
      @(negedge clk);
    end
    evtReady = 1'b0;
  endtask

  task automatic setPin(int c, bit v, int d);
    @(posedge clk);
    #(d);
    evtPin[c] = v;
  endtask

  task automatic idle(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
  endtask

  initial begin
    longint t1, s1, tA, tB;
    int n;
    idle(3);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "valid after reset", evtValid, 0);
    chk("R1", "overflow after reset", overflow, 0);

    // R2: two-cycle latency
    curReq = "R2";
    chEnable = 2'b11; riseEn = 2'b01; fallEn = 2'b00;
    idle(2);
    @(posedge clk); #2 evtPin[0] = 1'b1;
    @(posedge clk); t1 = tNs; s1 = tSec;
    @(negedge clk); chk("R2", "valid after sampling edge", evtValid, 0);
    @(negedge clk); chk("R2", "valid one edge later", evtValid, 0);
    @(negedge clk); chk("R2", "valid two edges later", evtValid, 1);
    chk("R2", "stamp ns", evtNs, t1 + 16);
    chk("R2", "stamp sec", evtSec, s1);
    chk("R6", "channel of ch0 event", evtChan, 0);
    setPin(0, 0, 2); idle(5);
    drain(n);
    chk("R2", "entries from one rise", n, 1);

    // R3: falling only, then both edges
    curReq = "R3";
    riseEn = 2'b00; fallEn = 2'b01;
    setPin(0, 1, 2); idle(5);
    chk("R3", "rise ignored with fall select", evtValid, 0);
    setPin(0, 0, 2); idle(5);
    drain(n);
    chk("R3", "entries from fall select", n, 1);
    riseEn = 2'b01; fallEn = 2'b01;
    setPin(0, 1, 2); repeat (3) @(posedge clk); setPin(0, 0, 2);
    idle(5);
    drain(n);
    chk("R3", "entries with both edges", n, 2);
    chk("R3", "edge spacing ns", drNs[1] - drNs[0], 32);

    // R4: disabled channels
    curReq = "R4";
    chEnable = 2'b00; riseEn = 2'b11; fallEn = 2'b11;
    setPin(0, 1, 2); evtPin[1] = 1'b1;
    idle(3);
    setPin(0, 0, 3); evtPin[1] = 1'b0;
    idle(6);
    chk("R4", "no entry while disabled", evtValid, 0);
    chEnable = 2'b11; fallEn = 2'b00;

    // R6: channel 1 index
    curReq = "R6";
    riseEn = 2'b10;
    setPin(1, 1, 2); idle(5);
    chk("R6", "channel of ch1 event", evtChan, 1);
    setPin(1, 0, 2);
    drain(n);
    chk("R6", "entries from ch1", n, 1);

    // R9: same-edge events on both channels
    curReq = "R9";
    riseEn = 2'b11;
    @(posedge clk); #2 evtPin = 2'b11;
    idle(5);
    drain(n);
    chk("R9", "entries from joint rise", n, 2);
    chk("R9", "first channel", drCh[0], 0);
    chk("R9", "second channel", drCh[1], 1);
    chk("R9", "equal stamps", drNs[1], drNs[0]);
    @(posedge clk); #2 evtPin = 2'b00;
    idle(4);

    // R10: boundary split
    curReq = "R10";
    riseEn = 2'b01;
    @(posedge clk); #7 evtPin[0] = 1'b1;
    @(posedge clk); tA = tNs;
    idle(5);
    drain(n);
    chk("R10", "change before edge stamp", drNs[0], tA + 16);
    setPin(0, 0, 2); idle(4);
    @(posedge clk); tB = tNs; #1 evtPin[0] = 1'b1;
    idle(6);
    drain(n);
    chk("R10", "change after edge stamp", drNs[0], tB + 24);
    setPin(0, 0, 2); idle(4);

    // R5: borrow into seconds
    curReq = "R5";
    corrVal = 40;
    @(posedge clk); #1 tNs = '0; #1 evtPin[0] = 1'b1;
    @(posedge clk); t1 = tNs; s1 = tSec;
    idle(5);
    drain(n);
    chk("R5", "borrow ns", drNs[0], t1 + 16 - 40 + NSPS);
    chk("R5", "borrow sec", drSec[0], s1 - 1);
    setPin(0, 0, 2); idle(4);
    // R5: carry into seconds
    corrVal = -40;
    @(posedge clk); #1 tNs = 30'd999999960; #1 evtPin[0] = 1'b1;
    @(posedge clk); t1 = tNs; s1 = tSec;
    idle(5);
    drain(n);
    chk("R5", "carry ns", drNs[0], t1 + 16 + 40 - NSPS);
    chk("R5", "carry sec", drSec[0], s1 + 1);
    setPin(0, 0, 2); idle(4);
    corrVal = 0;

    // R7 / R8: fill, overflow, order
    curReq = "R7";
    for (int k = 0; k < 8; k++) begin
      setPin(0, 1, 2); @(posedge clk); setPin(0, 0, 2);
    end
    idle(5);
    chk("R7", "queue full holds entries", evtValid, 1);
    chk("R8", "no loss at exactly full", overflow, 0);
    curReq = "R8";
    for (int k = 0; k < 2; k++) begin
      setPin(0, 1, 2); @(posedge clk); setPin(0, 0, 2);
    end
    idle(5);
    chk("R8", "loss flag set", overflow, 1);
    curReq = "R7";
    drain(n);
    chk("R7", "entries kept", n, 8);
    for (int k = 1; k < 8; k++)
      chk("R7", "oldest first", longint'(drNs[k] > drNs[k-1]), 1);
    idle(3);
    chk("R8", "loss flag sticky after drain", overflow, 1);

    done = 1;
    summary();
    $finish;
  end

  initial begin
    #1600000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

endmodule